// File: doc/BRIEF.md
# Wakeup interrupt polarity conditioner

This block sits between a bank of asynchronous interrupt or wakeup lines and a parent interrupt controller. The parent understands only two kinds of input: rising-edge events and active-high levels. Each incoming line has its own enable bit and its own 3-bit sense selection. The block re-times every line into the local clock domain. It then turns what it sees into the form the parent expects. Low levels are inverted. Falling edges and transitions in either direction become one-cycle high pulses. Rising edges and high levels pass as they are.

Software programs the block through a plain 32-bit register port. Writes are strobed and reads are combinational from the address. Enable bits are packed 32 to a word, starting at byte address 0x010. Sense selections take one word per line, starting at byte address 0x110. A line that is disabled, or that holds an unsupported sense code, keeps its output low.

Top module: `wkup_polarity_cond`

## Requirements
- R1: After reset every enable bit reads 0, every line's sense field reads 3'b100, and every output is low.
- R2: An output is never high while its line's enable bit is clear, and a clear that commits in the same cycle as a detected edge suppresses that pulse.
- R3: With sense code 3'b100 (active-high level) an enabled output equals the input as sampled two clocks earlier.
- R4: With sense code 3'b000 (active-low level) an enabled output is the inverse of the input as sampled two clocks earlier.
- R5: With sense code 3'b110 (rising edge) each low-to-high input transition gives exactly one output cycle high, in the second cycle after the change; a high-to-low transition gives none.
- R6: With sense code 3'b010 (falling edge) each high-to-low transition gives exactly one output cycle high; a low-to-high transition gives none.
- R7: With sense code 3'b111 (either edge) each transition in either direction gives exactly one output cycle high.
- R8: Sense codes 3'b001, 3'b011 and 3'b101 hold the output low until a legal code is written.
- R9: Line n is enabled by bit n mod 32 of the word at byte address 0x010 + 4*(n div 32); bits of that bank for lines that do not exist read 0.
- R10: Line n's sense field is bits [2:0] of the word at byte address 0x110 + 4*n; a read returns the stored field with bits [31:3] as 0.
- R11: An address outside both banks, or one not a multiple of 4, reads 0 and a write to it changes no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe; the write commits at the next rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| line_in | input | 168 | Asynchronous interrupt and wakeup inputs |
| line_out | output | 168 | Conditioned outputs to the parent controller |

## Verification
A register write that clears or sets an enable can land in the same clock edge where the re-timed input first shows an edge. Both functions then decide the same output cycle. The bench provokes this by changing the input one cycle before it strobes the enable write, so the write commits at the edge where the second synchroniser stage takes the new value. It then checks the output in that cycle: a clearing write must leave it low, and a setting write must let the pulse through. The remaining checks walk a table of sense code, enable, old and new input level. Each entry has an expected output for the pulse cycle and for the cycle after it.

// File: rtl/wkc_pkg.sv
package wkc_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned SENSE_W = 3;

    // Byte addresses of the two register banks
    localparam int unsigned EN_BASE  = 32'h010;
    localparam int unsigned CFG_BASE = 32'h110;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LVL_LO = 3'b000,
        SENSE_FALL   = 3'b010,
        SENSE_LVL_HI = 3'b100,
        SENSE_RISE   = 3'b110,
        SENSE_BOTH   = 3'b111
    } sense_e;

    localparam logic [SENSE_W-1:0] SENSE_RESET = SENSE_LVL_HI;

    function automatic logic sense_legal(input logic [SENSE_W-1:0] code);
        case (code)
            SENSE_LVL_LO, SENSE_FALL, SENSE_LVL_HI, SENSE_RISE, SENSE_BOTH: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/wkc_regs.sv
module wkc_regs
    import wkc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 168,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr,
    input  logic [REG_W-1:0]               wdata,
    output logic [REG_W-1:0]               rdata,
    output logic [NUM_LINES-1:0]           en_o,
    output logic [NUM_LINES*SENSE_W-1:0]   cfg_o
);

    localparam int unsigned EN_WORDS = (NUM_LINES + REG_W - 1) / REG_W;
    localparam int unsigned EN_SPAN  = EN_WORDS * 4;
    localparam int unsigned CFG_SPAN = NUM_LINES * 4;
    localparam logic [NUM_LINES*SENSE_W-1:0] CFG_RST = {NUM_LINES{SENSE_RESET}};

    typedef struct packed {
        logic [NUM_LINES-1:0]         en;
        logic [NUM_LINES*SENSE_W-1:0] cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [31:0]               addr32;
    logic [31:0]               en_off;
    logic [31:0]               cfg_off;
    logic                      en_hit;
    logic                      cfg_hit;
    int unsigned               en_idx;
    int unsigned               cfg_idx;
    logic [EN_WORDS*REG_W-1:0] en_pad;

    always_comb begin
        addr32  = 32'(addr);
        en_off  = addr32 - EN_BASE;
        cfg_off = addr32 - CFG_BASE;
        en_hit  = (addr32 >= EN_BASE)  && (en_off  < EN_SPAN)  && (addr32[1:0] == 2'b00);
        cfg_hit = (addr32 >= CFG_BASE) && (cfg_off < CFG_SPAN) && (addr32[1:0] == 2'b00);
        en_idx  = en_off >> 2;
        cfg_idx = cfg_off >> 2;

        en_pad                 = '0;
        en_pad[NUM_LINES-1:0]  = regs_q.en;

        regs_d = regs_q;
        rdata  = '0;

        if (en_hit) begin
            rdata = en_pad[en_idx*REG_W +: REG_W];
            if (wr) begin
                for (int b = 0; b < int'(REG_W); b++) begin
                    if (en_idx*REG_W + b < NUM_LINES) begin
                        regs_d.en[en_idx*REG_W + b] = wdata[b];
                    end
                end
            end
        end

        if (cfg_hit) begin
            rdata = {{(REG_W-SENSE_W){1'b0}}, regs_q.cfg[cfg_idx*SENSE_W +: SENSE_W]};
            if (wr) begin
                regs_d.cfg[cfg_idx*SENSE_W +: SENSE_W] = wdata[SENSE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.en  <= '0;
            regs_q.cfg <= CFG_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_o  = regs_q.en;
    assign cfg_o = regs_q.cfg;

endmodule

// File: rtl/wkc_sync.sv
module wkc_sync #(
    parameter int unsigned NUM_LINES = 168
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_i,
    output logic [NUM_LINES-1:0] lvl_o,
    output logic [NUM_LINES-1:0] prev_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] meta;
        logic [NUM_LINES-1:0] lvl;
        logic [NUM_LINES-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = raw_i;
        sync_d.lvl  = sync_q.meta;
        sync_d.prev = sync_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl_o  = sync_q.lvl;
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/wkc_sense.sv
module wkc_sense
    import wkc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 168
) (
    input  logic [NUM_LINES-1:0]         en_i,
    input  logic [NUM_LINES*SENSE_W-1:0] cfg_i,
    input  logic [NUM_LINES-1:0]         lvl_i,
    input  logic [NUM_LINES-1:0]         prev_i,
    output logic [NUM_LINES-1:0]         out_o
);

    for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_line
        logic [SENSE_W-1:0] code;
        logic               cond;

        assign code = cfg_i[g*SENSE_W +: SENSE_W];

        always_comb begin
            case (code)
                SENSE_LVL_HI: cond = lvl_i[g];
                SENSE_LVL_LO: cond = ~lvl_i[g];
                SENSE_RISE:   cond = lvl_i[g] & ~prev_i[g];
                SENSE_FALL:   cond = ~lvl_i[g] & prev_i[g];
                SENSE_BOTH:   cond = lvl_i[g] ^ prev_i[g];
                default:      cond = 1'b0;
            endcase
        end

        assign out_o[g] = en_i[g] & cond;
    end

endmodule

// File: rtl/wkup_polarity_cond.sv
module wkup_polarity_cond
    import wkc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 168,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] line_out
);

    logic [NUM_LINES-1:0]         en_vec;
    logic [NUM_LINES*SENSE_W-1:0] cfg_flat;
    logic [NUM_LINES-1:0]         sync_lvl;
    logic [NUM_LINES-1:0]         sync_prev;

    wkc_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .en_o  (en_vec),
        .cfg_o (cfg_flat)
    );

    wkc_sync #(
        .NUM_LINES (NUM_LINES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (line_in),
        .lvl_o  (sync_lvl),
        .prev_o (sync_prev)
    );

    wkc_sense #(
        .NUM_LINES (NUM_LINES)
    ) u_sense (
        .en_i   (en_vec),
        .cfg_i  (cfg_flat),
        .lvl_i  (sync_lvl),
        .prev_i (sync_prev),
        .out_o  (line_out)
    );

endmodule

// File: rtl/wkc_checker.sv
module wkc_checker
    import wkc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 168,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_LINES-1:0]         line_in,
    input logic [NUM_LINES-1:0]         line_out,
    input logic [NUM_LINES-1:0]         en_vec,
    input logic [NUM_LINES*SENSE_W-1:0] cfg_flat,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [31:0]                  reg_rdata
);

    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out & ~en_vec) == '0); // R2

    AST_LOW_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < ADDR_W'(EN_BASE)) |-> (reg_rdata == 32'd0)); // R11

    for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_chk
        logic [SENSE_W-1:0] code;
        assign code = cfg_flat[g*SENSE_W +: SENSE_W];

        AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && en_vec[g] && code == SENSE_LVL_HI)
            |-> (line_out[g] == $past(line_in[g], 2))); // R3

        AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd3 && en_vec[g] && code == SENSE_LVL_LO)
            |-> (line_out[g] == !$past(line_in[g], 2))); // R4

        AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (line_out[g] && (code == SENSE_RISE || code == SENSE_FALL))
            |=> (!line_out[g] || code != $past(code))); // R5 R6

        AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !sense_legal(code) |-> !line_out[g]); // R8
    end

endmodule

bind wkup_polarity_cond wkc_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (line_in),
    .line_out  (line_out),
    .en_vec    (en_vec),
    .cfg_flat  (cfg_flat),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/tb_wkup_polarity_cond.sv
module tb_wkup_polarity_cond;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 168;
    localparam int AW         = 12;
    localparam int LN         = 37;                 // line under test: word 1, bit 5
    localparam logic [AW-1:0] EN_ADDR_LN  = 12'h014;
    localparam logic [AW-1:0] CFG_ADDR_LN = 12'h110 + 12'(4*LN);

    // {code[2:0], enable, level before, level after, expected in pulse cycle, expected after}
    localparam logic [7:0] VEC [16] = '{
        {3'b100, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'b110, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {3'b111, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {3'b011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] line_in = '0;
    logic [NL-1:0] line_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wkup_polarity_cond #(.NUM_LINES(NL), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .line_in   (line_in),
        .line_out  (line_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // called at a falling edge; commits at the next rising edge, returns at the following falling edge
    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_fall(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] code, input logic en);
        if (!en) return "R2";
        case (code)
            3'b100:  return "R3";
            3'b000:  return "R4";
            3'b110:  return "R5";
            3'b010:  return "R6";
            3'b111:  return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int          bad;

        wait_fall(3);
        rst_n = 1'b1;
        wait_fall(2);

        // R1: reset state
        check("R1 outputs", 32'(line_out != '0), 32'd0);
        reg_read(12'h010, rd); check("R1 enable word 0", rd, 32'd0);
        reg_read(12'h024, rd); check("R1 enable word 5", rd, 32'd0);
        bad = 0;
        for (int l = 0; l < NL; l++) begin
            reg_read(12'h110 + 12'(4*l), rd);
            if (rd != 32'd4) bad++;
        end
        check("R1 sense fields", 32'(bad), 32'd0);
        @(negedge clk);

        // table walk on one line
        for (int v = 0; v < 16; v++) begin
            logic [2:0] code;
            logic       en, lb, la, ew, ea;
            string      tg;
            {code, en, lb, la, ew, ea} = VEC[v];
            tg = tag_of(code, en);
            line_in[LN] = lb;
            reg_write(CFG_ADDR_LN, 32'(code));
            reg_write(EN_ADDR_LN, en ? 32'h20 : 32'h0);
            wait_fall(4);
            line_in[LN] = la;
            wait_fall(2);
            check($sformatf("%s vec %0d pulse cycle", tg, v), 32'(line_out[LN]), 32'(ew));
            check($sformatf("R2 vec %0d other lines", v),
                  32'((line_out & ~(NL'(1) << LN)) != '0), 32'd0);
            wait_fall(1);
            check($sformatf("%s vec %0d after", tg, v), 32'(line_out[LN]), 32'(ea));
            reg_write(EN_ADDR_LN, 32'h0);
            line_in[LN] = 1'b0;
            wait_fall(3);
        end

        // R2: enable cleared in the same edge that the edge reaches the detector
        reg_write(CFG_ADDR_LN, 32'h6);
        reg_write(EN_ADDR_LN, 32'h20);
        wait_fall(3);
        line_in[LN] = 1'b1;
        @(negedge clk);
        reg_write(EN_ADDR_LN, 32'h0);
        check("R2 clear meets edge", 32'(line_out[LN]), 32'd0);
        line_in[LN] = 1'b0;
        wait_fall(4);
        // enable set in the same edge: pulse passes
        line_in[LN] = 1'b1;
        @(negedge clk);
        reg_write(EN_ADDR_LN, 32'h20);
        check("R5 set meets edge", 32'(line_out[LN]), 32'd1);
        @(negedge clk);
        check("R5 single cycle", 32'(line_out[LN]), 32'd0);
        reg_write(EN_ADDR_LN, 32'h0);
        line_in[LN] = 1'b0;
        reg_write(CFG_ADDR_LN, 32'h4);
        wait_fall(3);

        // R9: enable bank mapping and unused bits
        reg_write(12'h010, 32'hA5A5_0001);
        reg_read(12'h010, rd); check("R9 word 0 readback", rd, 32'hA5A5_0001);
        reg_write(12'h010, 32'h0);
        reg_write(12'h024, 32'hFFFF_FFFF);
        reg_read(12'h024, rd); check("R9 last word bits", rd, 32'h0000_00FF);
        line_in[NL-1] = 1'b1;
        wait_fall(2);
        check("R9 line 167 enabled", 32'(line_out[NL-1]), 32'd1);
        check("R9 line 166 idle", 32'(line_out[NL-2]), 32'd0);
        reg_write(12'h024, 32'h0);
        line_in[NL-1] = 1'b0;
        wait_fall(3);

        // R10: sense field storage width
        reg_write(12'h11C, 32'hFFFF_FFF6);
        reg_read(12'h11C, rd); check("R10 field masked", rd, 32'h6);
        reg_write(12'h3AC, 32'h7);
        reg_read(12'h3AC, rd); check("R10 last line", rd, 32'h7);
        reg_write(12'h3AC, 32'h4);
        reg_write(12'h11C, 32'h4);

        // R11: out-of-range and unaligned accesses
        reg_write(12'h028, 32'hFFFF_FFFF);
        reg_read(12'h028, rd); check("R11 past enable bank", rd, 32'd0);
        reg_read(12'h024, rd); check("R11 last enable word intact", rd, 32'd0);
        reg_write(12'h3B0, 32'h1);
        reg_read(12'h3B0, rd); check("R11 past sense bank", rd, 32'd0);
        reg_write(12'h111, 32'h0);
        reg_read(12'h111, rd); check("R11 unaligned read", rd, 32'd0);
        reg_read(12'h110, rd); check("R11 line 0 intact", rd, 32'd4);
        reg_write(12'h00C, 32'hFFFF_FFFF);
        reg_read(12'h00C, rd); check("R11 low address", rd, 32'd0);
        reg_read(12'h010, rd); check("R11 enable word 0 intact", rd, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule